// File: doc/BRIEF.md
# Switching Clock Source Manager

This block decides where the switching clock of a regulator controller comes from and produces it. A decoded three-way configuration strap picks one of three modes. In external-input mode and auto-detect mode the block watches a sync line and checks it for a valid clock. It measures the period of that clock in reference-clock cycles. Once it accepts the clock, a digital divider runs at the measured period and restarts its phase on every valid rising edge. In clock-output mode the block runs from its own divider and enables the sync line as an output so that other controllers can follow it.

Detection starts once, at the first start. That is the supply-good indication when the device is self-enabled or monitoring. It is the enable input when the device is in low-power mode. Detection lasts a fixed window. If no valid clock is found within it, the divider runs at a default period. In auto-detect mode that period comes instead from a frequency strap, which is captured at that first start and kept until reset. If an accepted external clock later disappears, the divider keeps running at the last measured period and reports the fallback.

All periods are counted in reference-clock cycles. With a 50 MHz reference, the defaults map to the following: the accepted band of 36 to 250 cycles covers roughly 1.4 MHz down to 200 kHz, the 125-cycle default gives 400 kHz, and the strap choices give 200 kHz, 400 kHz and 1 MHz.

Top module: `clk_src_mgr`

## Requirements
- R1: During and right after reset, `sw_clk`, `sync_oe` and `src_status` are 0. `src_status` encodes 0 = not running, 1 = internal divider (default or strap), 2 = locked to the external clock, 3 = internal divider after loss of the external clock.
- R2: The first start is taken at a clock edge where `supply_good` is high if `low_power` is 0, or where `en` is high if `low_power` is 1. Before that start the outputs stay as in R1.
- R3: With `mode_strap` = 2'b10 (output mode), the start sets `src_status` to 1 and `sync_oe` to 1, and the divider runs at `PER_DEF` (125) cycles. Activity on `sync_in` never changes the status or the period in this mode.
- R4: With `mode_strap` = 2'b00 (input) or 2'b01/2'b11 (auto-detect), an external clock is accepted after 4 consecutive periods of `PER_MIN`..`PER_MAX` (36..250) cycles inclusive, all within the detection window. The first measured edge only starts the count. On acceptance `src_status` becomes 2 and `sw_clk` takes the measured period.
- R5: A period outside the accepted band clears the run of consecutive good periods. Another 4 good periods are then needed.
- R6: While locked, each in-range rising edge of `sync_in` restarts the divider phase. `sw_clk` rises on the third reference-clock rising edge after `sync_in` goes high.
- R7: In input mode, if no clock is accepted within `DETECT_WIN` (1500) cycles after the start, `src_status` becomes 1 and the period is `PER_DEF`.
- R8: In auto-detect mode with no clock accepted in the window, the period comes from `freq_strap`: 2'b00 gives 250 cycles, 2'b10 gives 50, and 2'b01/2'b11 give 125. `src_status` becomes 1.
- R9: `freq_strap` is captured at the start. Later changes have no effect until reset.
- R10: While locked, if no rising edge arrives for 2·`PER_MAX` (500) cycles, `src_status` becomes 3. The divider keeps running at the last accepted period without a phase jump.
- R11: After a fallback, rising edges on `sync_in` cause neither a relock, a phase restart nor a period change.
- R12: If the fourth good period ends in the last cycle of the detection window, the lock takes priority and `src_status` becomes 2.
- R13: `sw_clk` is high for floor(P/2) cycles and low for the rest of each period P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference system clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| sync_in | input | 1 | Sync line as sampled from the pad |
| mode_strap | input | 2 | Decoded configuration strap: 00 input, 01/11 auto-detect, 10 output |
| freq_strap | input | 2 | Decoded frequency strap used in auto-detect fallback |
| low_power | input | 1 | 1: start on enable; 0: start on supply-good |
| en | input | 1 | Enable |
| supply_good | input | 1 | Internal supply-good indication |
| sw_clk | output | 1 | Switching clock |
| sync_oe | output | 1 | Drive `sw_clk` onto the sync line |
| src_status | output | 2 | Active clock source (see R1) |

## Verification
Two of the block's functions can act in the same cycle. The last cycle of the detection window can also be the cycle in which the fourth good period is confirmed. The bench provokes this by counting cycles from the start and placing the external edges so that the confirming edge lands exactly on the window's last cycle, and then one cycle later. The first case must end locked (status 2) and the second on the internal divider (status 1). A behavioural model checks every cycle of both runs.

// File: rtl/clk_src_pkg.sv
// Shared types for the switching clock source manager.
// Assumes the configuration strap arrives already decoded to two bits.
package clk_src_pkg;

    typedef enum logic [1:0] {
        MODE_IN   = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_OUT  = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'b00,
        SRC_INT      = 2'b01,
        SRC_EXT      = 2'b10,
        SRC_FALLBACK = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DETECT,
        ST_EXT,
        ST_INT
    } ctl_state_e;

    // Map the decoded strap to a mode; the unused code behaves as auto-detect.
    function automatic mode_e decode_mode(input logic [1:0] strap);
        case (strap)
            2'b00:   return MODE_IN;
            2'b10:   return MODE_OUT;
            default: return MODE_AUTO;
        endcase
    endfunction

endpackage

// File: rtl/clk_src_sync_edge.sv
// Synchronizes the asynchronous sync line into the reference domain and
// flags its rising edges. Assumes the line is slow against the reference.
// Latency: an input rise before edge k shows as a pulse sampled at edge k+STAGES.
module clk_src_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] shreg;

    // Shift the line through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], din};
        end
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/clk_src_period_meter.sv
// Measures the spacing of sync rising edges in reference cycles, counts
// consecutive in-range periods, and flags loss when the gap saturates.
// Assumes the meter is cleared whenever enable is low.
module clk_src_period_meter #(
    parameter int PER_MIN   = 36,
    parameter int PER_MAX   = 250,
    parameter int VALID_RUN = 4,
    parameter int LOSS_CYC  = 500,
    parameter int CW        = 9,
    parameter int GW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          rise,
    output logic [CW-1:0] meas,
    output logic          ok_edge,
    output logic          lock_hit,
    output logic          lost
);

    localparam logic [GW-1:0] GOOD_TOP = GW'(VALID_RUN - 1);
    localparam logic [CW-1:0] MIN_C    = CW'(PER_MIN);
    localparam logic [CW-1:0] MAX_C    = CW'(PER_MAX);
    localparam logic [CW-1:0] LOSS_C   = CW'(LOSS_CYC);

    logic          armed;
    logic [GW-1:0] good;
    logic          in_range;

    assign in_range = armed && (meas >= MIN_C) && (meas <= MAX_C);
    assign ok_edge  = rise && in_range;
    assign lock_hit = ok_edge && (good == GOOD_TOP);
    assign lost     = armed && (meas == LOSS_C);

    // Track the gap since the last edge and the run of good periods.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed <= 1'b0;
            good  <= '0;
            meas  <= '0;
        end else if (rise) begin
            armed <= 1'b1;
            meas  <= CW'(1);
            if (in_range) begin
                good <= (good == GOOD_TOP) ? GOOD_TOP : good + 1'b1;
            end else begin
                good <= '0;
            end
        end else if (meas != LOSS_C) begin
            meas <= meas + 1'b1;
        end
    end

endmodule

// File: rtl/clk_src_osc.sv
// Programmable divider of the reference clock producing the switching clock.
// High for floor(period/2) cycles; restart forces the phase to zero.
// Assumes period is held stable by the controller between restarts.
module clk_src_osc #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [CW-1:0] period,
    output logic          sw_clk
);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, period};

    // Advance the phase counter, wrapping at the period or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sw_clk = run && (cnt < (period >> 1));

endmodule

// File: rtl/clk_src_ctrl.sv
// Source selection controller: takes the first start, runs the detection
// window, locks to or falls back from the external clock, and holds the
// strap values captured at start until reset.
// Assumes lock and loss indications come from the period meter.
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int PER_DEF       = 125,
    parameter int PER_STRAP_LO  = 250,
    parameter int PER_STRAP_MID = 125,
    parameter int PER_STRAP_HI  = 50,
    parameter int DETECT_WIN    = 1500,
    parameter int CW            = 9,
    parameter int WW            = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode_strap,
    input  logic [1:0]    freq_strap,
    input  logic          lock_hit,
    input  logic          ok_edge,
    input  logic          lost,
    input  logic [CW-1:0] meas,
    output logic          run,
    output logic          restart,
    output logic          meter_en,
    output logic          sync_oe,
    output logic [CW-1:0] per_q,
    output src_e          status
);

    localparam logic [WW-1:0] WIN_LAST = WW'(DETECT_WIN - 1);

    ctl_state_e    state;
    mode_e         mode_q;
    logic [1:0]    strap_q;
    logic [WW-1:0] win;
    logic          win_done;
    logic          start_out;

    // Period chosen by the captured frequency strap.
    function automatic logic [CW-1:0] strap_period(input logic [1:0] s);
        case (s)
            2'b00:   return CW'(PER_STRAP_LO);
            2'b10:   return CW'(PER_STRAP_HI);
            default: return CW'(PER_STRAP_MID);
        endcase
    endfunction

    assign win_done  = (win == WIN_LAST);
    assign start_out = (state == ST_IDLE) && start && (decode_mode(mode_strap) == MODE_OUT);
    assign run       = (state == ST_EXT) || (state == ST_INT);
    assign meter_en  = (state == ST_DETECT) || (state == ST_EXT);

    // Phase restarts: start of output mode, end of detection, accepted edges.
    always_comb begin
        restart = 1'b0;
        case (state)
            ST_IDLE:   restart = start_out;
            ST_DETECT: restart = lock_hit || win_done;
            ST_EXT:    restart = ok_edge && !lost;
            default:   restart = 1'b0;
        endcase
    end

    // Sequence the source selection and hold the captured strap values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_AUTO;
            strap_q <= 2'b00;
            win     <= '0;
            per_q   <= '0;
            status  <= SRC_NONE;
            sync_oe <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= decode_mode(mode_strap);
                        strap_q <= freq_strap;
                        win     <= '0;
                        if (start_out) begin
                            state   <= ST_INT;
                            status  <= SRC_INT;
                            per_q   <= CW'(PER_DEF);
                            sync_oe <= 1'b1;
                        end else begin
                            state <= ST_DETECT;
                        end
                    end
                end
                ST_DETECT: begin
                    if (lock_hit) begin
                        state  <= ST_EXT;
                        status <= SRC_EXT;
                        per_q  <= meas;
                    end else if (win_done) begin
                        state  <= ST_INT;
                        status <= SRC_INT;
                        per_q  <= (mode_q == MODE_AUTO) ? strap_period(strap_q) : CW'(PER_DEF);
                    end else begin
                        win <= win + 1'b1;
                    end
                end
                ST_EXT: begin
                    if (lost) begin
                        state  <= ST_INT;
                        status <= SRC_FALLBACK;
                    end else if (ok_edge) begin
                        per_q <= meas;
                    end
                end
                default: begin
                    state <= ST_INT;
                end
            endcase
        end
    end

endmodule

// File: rtl/clk_src_mgr.sv
// Top of the switching clock source manager: synchronizes the sync line,
// measures it, selects the clock source and drives the switching clock.
// Assumes straps are decoded and static except where the requirements allow.
module clk_src_mgr
    import clk_src_pkg::*;
#(
    parameter int PER_MIN       = 36,
    parameter int PER_MAX       = 250,
    parameter int PER_DEF       = 125,
    parameter int PER_STRAP_LO  = 250,
    parameter int PER_STRAP_MID = 125,
    parameter int PER_STRAP_HI  = 50,
    parameter int DETECT_WIN    = 1500,
    parameter int VALID_RUN     = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic [1:0] mode_strap,
    input  logic [1:0] freq_strap,
    input  logic       low_power,
    input  logic       en,
    input  logic       supply_good,
    output logic       sw_clk,
    output logic       sync_oe,
    output logic [1:0] src_status
);

    localparam int LOSS_CYC = 2 * PER_MAX;
    localparam int CW       = $clog2(LOSS_CYC + 1);
    localparam int WW       = $clog2(DETECT_WIN);
    localparam int GW       = (VALID_RUN > 1) ? $clog2(VALID_RUN) : 1;

    logic          rise;
    logic          meter_en;
    logic [CW-1:0] meas;
    logic          ok_edge;
    logic          lock_hit;
    logic          lost;
    logic          run;
    logic          restart;
    logic [CW-1:0] per_q;
    logic          start;
    src_e          status;

    assign start      = low_power ? en : supply_good;
    assign src_status = status;

    clk_src_sync_edge #(
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .rise (rise)
    );

    clk_src_period_meter #(
        .PER_MIN  (PER_MIN),
        .PER_MAX  (PER_MAX),
        .VALID_RUN(VALID_RUN),
        .LOSS_CYC (LOSS_CYC),
        .CW       (CW),
        .GW       (GW)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (meter_en),
        .rise    (rise),
        .meas    (meas),
        .ok_edge (ok_edge),
        .lock_hit(lock_hit),
        .lost    (lost)
    );

    clk_src_ctrl #(
        .PER_DEF      (PER_DEF),
        .PER_STRAP_LO (PER_STRAP_LO),
        .PER_STRAP_MID(PER_STRAP_MID),
        .PER_STRAP_HI (PER_STRAP_HI),
        .DETECT_WIN   (DETECT_WIN),
        .CW           (CW),
        .WW           (WW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_strap(mode_strap),
        .freq_strap(freq_strap),
        .lock_hit  (lock_hit),
        .ok_edge   (ok_edge),
        .lost      (lost),
        .meas      (meas),
        .run       (run),
        .restart   (restart),
        .meter_en  (meter_en),
        .sync_oe   (sync_oe),
        .per_q     (per_q),
        .status    (status)
    );

    clk_src_osc #(
        .CW(CW)
    ) u_osc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(restart),
        .period (per_q),
        .sw_clk (sw_clk)
    );

endmodule

// File: rtl/clk_src_mgr_chk.sv
// Assertion checker for the switching clock source manager, bound to the top.
// Assumes reset is held for at least one clock edge at time zero.
module clk_src_mgr_chk #(
    parameter int PER_MIN = 36,
    parameter int PER_MAX = 250,
    parameter int CW      = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_clk,
    input logic          sync_oe,
    input logic [1:0]    src_status,
    input logic [CW-1:0] per_q,
    input logic          meter_en
);

    // R1: nothing is driven while not running.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_status == 2'd0) |-> (!sw_clk && !sync_oe));

    // R3: the sync line is only driven from the internal divider.
    a_r3_oe_internal: assert property (@(posedge clk) disable iff (!rst_n)
        sync_oe |-> (src_status == 2'd1));

    // R4: the external lock is only entered from detection.
    a_r4_ext_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_status == 2'd2) && ($past(src_status) != 2'd2)) |-> ($past(src_status) == 2'd0));

    // R4: a locked period lies inside the accepted band.
    a_r4_ext_period_band: assert property (@(posedge clk) disable iff (!rst_n)
        (src_status == 2'd2) |-> ((per_q >= CW'(PER_MIN)) && (per_q <= CW'(PER_MAX))));

    // R10: fallback only follows an external lock, keeping its period.
    a_r10_fallback_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_status == 2'd3) && ($past(src_status) != 2'd3)) |-> (($past(src_status) == 2'd2) && (per_q == $past(per_q))));

    // R11: fallback is final and the sync line is no longer measured.
    a_r11_fallback_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (src_status == 2'd3) |=> ((src_status == 2'd3) && !meter_en && $stable(per_q)));

    // R2: once running, the block keeps running until reset.
    a_r2_stays_running: assert property (@(posedge clk) disable iff (!rst_n)
        (src_status != 2'd0) |=> (src_status != 2'd0));

endmodule

bind clk_src_mgr clk_src_mgr_chk #(
    .PER_MIN(PER_MIN),
    .PER_MAX(PER_MAX),
    .CW     (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_clk    (sw_clk),
    .sync_oe   (sync_oe),
    .src_status(src_status),
    .per_q     (per_q),
    .meter_en  (meter_en)
);

// File: tb/clk_src_mgr_bench.sv
// Self-checking bench: a behavioural cycle model compared on every clock,
// plus directed checks of periods and status per requirement.
module clk_src_mgr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PMIN = 36, PMAX = 250, PDEF = 125;
    localparam int WIN = 1500, VALID = 4, LOSS = 500;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic [1:0] mode_strap = 2'b01;
    logic [1:0] freq_strap = 2'b01;
    logic low_power = 1'b0;
    logic en = 1'b0;
    logic supply_good = 1'b0;
    logic sw_clk, sync_oe;
    logic [1:0] src_status;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_mgr u_clk_src_mgr (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .mode_strap(mode_strap), .freq_strap(freq_strap),
        .low_power(low_power), .en(en), .supply_good(supply_good),
        .sw_clk(sw_clk), .sync_oe(sync_oe), .src_status(src_status)
    );

    // Reference model: states 0 idle, 1 detect, 2 external, 3 internal.
    int m_s1, m_s2, m_s3, m_state, m_mode, m_strap, m_win, m_per;
    int m_status, m_oe, m_cnt, m_meas, m_armed, m_good;
    bit m_edge, m_men, m_inr, m_lock, m_lost, m_okedge, m_start, m_done, m_restart;
    bit exp_clk;

    function automatic int strap_per(int s);
        if (s == 0) return 250;
        if (s == 2) return 50;
        return 125;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_state = 0; m_mode = 1; m_strap = 0;
            m_win = 0; m_per = 0; m_status = 0; m_oe = 0; m_cnt = 0;
            m_meas = 0; m_armed = 0; m_good = 0;
        end else begin
            m_edge   = (m_s2 == 1) && (m_s3 == 0);
            m_men    = (m_state == 1) || (m_state == 2);
            m_inr    = m_men && m_armed == 1 && m_meas >= PMIN && m_meas <= PMAX;
            m_okedge = m_edge && m_inr;
            m_lock   = m_okedge && m_good >= VALID - 1;
            m_lost   = m_men && m_armed == 1 && m_meas == LOSS;
            m_start  = low_power ? en : supply_good;
            m_done   = (m_win == WIN - 1);
            m_restart = 0;
            if (m_state == 0 && m_start && mode_strap == 2'b10) m_restart = 1;
            if (m_state == 1 && (m_lock || m_done)) m_restart = 1;
            if (m_state == 2 && m_okedge && !m_lost) m_restart = 1;
            // divider, using the period held before this edge
            if (m_restart || m_cnt + 1 >= m_per) m_cnt = 0; else m_cnt++;
            // meter
            if (!m_men) begin
                m_meas = 0; m_armed = 0; m_good = 0;
            end else if (m_edge) begin
                m_good = m_inr ? ((m_good >= VALID - 1) ? VALID - 1 : m_good + 1) : 0;
                m_armed = 1; m_meas = 1;
            end else if (m_meas != LOSS) begin
                m_meas++;
            end
            // controller
            case (m_state)
                0: if (m_start) begin
                    m_mode = (mode_strap == 2'b00) ? 0 : (mode_strap == 2'b10) ? 2 : 1;
                    m_strap = freq_strap; m_win = 0;
                    if (m_mode == 2) begin m_state = 3; m_status = 1; m_per = PDEF; m_oe = 1; end
                    else m_state = 1;
                end
                1: if (m_lock) begin
                    m_state = 2; m_status = 2; m_per = m_meas_pre;
                end else if (m_done) begin
                    m_state = 3; m_status = 1; m_per = (m_mode == 1) ? strap_per(m_strap) : PDEF;
                end else m_win++;
                2: if (m_lost) begin m_state = 3; m_status = 3; end
                   else if (m_okedge) m_per = m_meas_pre;
                default: ;
            endcase
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
    end

    // Period seen at this edge, captured before the meter model updates it.
    int m_meas_pre;
    always @(negedge clk) m_meas_pre = m_meas;

    // Compare the design with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            exp_clk = (m_state == 2 || m_state == 3) && (m_cnt < m_per / 2);
            checks++;
            if (sw_clk !== exp_clk || sync_oe !== m_oe[0] || src_status !== m_status[1:0]) begin
                errors++;
                $display("FAIL %s model: clk=%0b oe=%0b st=%0d expected clk=%0b oe=%0b st=%0d",
                         cur_req, sw_clk, sync_oe, src_status, exp_clk, m_oe[0], m_status);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !done) begin
            errors++;
            $display("FAIL watchdog (all requirements): cycle %0d expected end before %0d", cyc, WD_LIMIT);
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; supply_good = 1'b0; en = 1'b0; sync_in = 1'b0;
        repeat (5) @(negedge clk);
        cmp_on = 1;
        chk(sw_clk == 1'b0 && sync_oe == 1'b0 && src_status == 2'd0, "R1 reset outputs",
            {29'd0, sw_clk, sync_oe, src_status[0]} | src_status, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ext_pulses(input int per, input int n);
        for (int i = 0; i < n; i++) begin
            sync_in = 1'b1;
            repeat (per / 2) @(negedge clk);
            sync_in = 1'b0;
            repeat (per - per / 2) @(negedge clk);
        end
    endtask

    task automatic measure(output int per, output int hi);
        int lo = 0;
        int guard = 0;
        hi = 0;
        while (sw_clk == 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
        while (sw_clk == 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (sw_clk == 1'b1 && guard < 6000) begin @(negedge clk); hi++; guard++; end
        while (sw_clk == 1'b0 && guard < 8000) begin @(negedge clk); lo++; guard++; end
        per = hi + lo;
    endtask

    task automatic start_supply(input logic [1:0] mode, input logic [1:0] fs);
        mode_strap = mode; freq_strap = fs; low_power = 1'b0;
        supply_good = 1'b1;
    endtask

    int p, h;

    initial begin
        // R1, R2, R8, R9, R13: auto-detect, no clock, strap low.
        cur_req = "R1";
        do_reset();
        cur_req = "R2";
        mode_strap = 2'b01; freq_strap = 2'b00; low_power = 1'b0; en = 1'b1;
        repeat (40) @(negedge clk);
        chk(src_status == 2'd0, "R2 enable ignored before supply-good", src_status, 0);
        chk(sw_clk == 1'b0, "R2 clock idle before start", sw_clk, 0);
        cur_req = "R8";
        start_supply(2'b01, 2'b00);
        repeat (WIN + 10) @(negedge clk);
        chk(src_status == 2'd1, "R8 status after window", src_status, 1);
        measure(p, h);
        chk(p == 250, "R8 strap low period", p, 250);
        chk(h == 125, "R13 high time", h, 125);
        cur_req = "R9";
        freq_strap = 2'b10;
        repeat (300) @(negedge clk);
        measure(p, h);
        chk(p == 250, "R9 strap change ignored", p, 250);

        // R8: strap high and open.
        cur_req = "R8";
        do_reset();
        start_supply(2'b01, 2'b10);
        repeat (WIN + 10) @(negedge clk);
        measure(p, h);
        chk(p == 50, "R8 strap high period", p, 50);
        do_reset();
        start_supply(2'b11, 2'b01);
        repeat (WIN + 10) @(negedge clk);
        measure(p, h);
        chk(p == 125, "R8 strap open period", p, 125);
        chk(h == 62, "R13 odd period high time", h, 62);

        // R2, R3: output mode started by enable in low-power mode.
        cur_req = "R2";
        do_reset();
        mode_strap = 2'b10; low_power = 1'b1; supply_good = 1'b1;
        repeat (40) @(negedge clk);
        chk(src_status == 2'd0, "R2 supply-good ignored in low-power", src_status, 0);
        cur_req = "R3";
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(sync_oe == 1'b1, "R3 sync output enabled", sync_oe, 1);
        chk(src_status == 2'd1, "R3 internal status", src_status, 1);
        ext_pulses(100, 20);
        chk(src_status == 2'd1, "R3 sync input ignored", src_status, 1);
        measure(p, h);
        chk(p == PDEF, "R3 default period", p, PDEF);

        // R4, R6, R10, R11: input mode lock, loss, ignored edges.
        cur_req = "R6";
        do_reset();
        start_supply(2'b00, 2'b00);
        fork
            ext_pulses(100, 15);
            begin
                repeat (900) @(negedge clk);
                chk(src_status == 2'd2, "R4 locked status", src_status, 2);
                measure(p, h);
                chk(p == 100, "R4 locked period", p, 100);
                chk(h == 50, "R13 locked high time", h, 50);
            end
        join
        cur_req = "R10";
        repeat (LOSS + 20) @(negedge clk);
        chk(src_status == 2'd3, "R10 fallback status", src_status, 3);
        measure(p, h);
        chk(p == 100, "R10 kept period", p, 100);
        cur_req = "R11";
        fork
            ext_pulses(60, 20);
            begin
                repeat (400) @(negedge clk);
                measure(p, h);
            end
        join
        chk(src_status == 2'd3, "R11 no relock", src_status, 3);
        chk(p == 100, "R11 period unchanged", p, 100);

        // R5, R7: out-of-range clock, then a broken run of good periods.
        cur_req = "R5";
        do_reset();
        start_supply(2'b00, 2'b10);
        ext_pulses(30, 50);
        repeat (WIN) @(negedge clk);
        chk(src_status == 2'd1, "R5 fast clock rejected", src_status, 1);
        cur_req = "R7";
        measure(p, h);
        chk(p == PDEF, "R7 input-mode default period", p, PDEF);
        cur_req = "R5";
        do_reset();
        start_supply(2'b00, 2'b00);
        ext_pulses(100, 3);
        ext_pulses(30, 1);
        ext_pulses(100, 3);
        repeat (WIN) @(negedge clk);
        chk(src_status == 2'd1, "R5 bad period clears run", src_status, 1);

        // R12: fourth good period on the window's last cycle, then one later.
        cur_req = "R12";
        do_reset();
        start_supply(2'b00, 2'b00);
        repeat (1098) @(negedge clk);
        ext_pulses(100, 5);
        repeat (20) @(negedge clk);
        chk(src_status == 2'd2, "R12 lock wins at window end", src_status, 2);
        do_reset();
        start_supply(2'b00, 2'b00);
        repeat (1099) @(negedge clk);
        ext_pulses(100, 5);
        repeat (20) @(negedge clk);
        chk(src_status == 2'd1, "R12 window expired first", src_status, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule